// File: doc/BRIEF.md
# Paged Program Counter with Interrupt Context Shadow

This block holds the 14-bit instruction address of a small 8-bit controller core and decides, once per clock, where that address goes next. It receives strobes that the instruction decoder has already resolved. These strobes ask for a sequential step, an absolute jump or call, a write of the accumulator into the low address byte (as a move or as an add), a table-relative offset, a subroutine return, or a return from interrupt. An interrupt request line also feeds the block. The four address bits above the low ten come from a separate page-select register that software writes. Jumps, calls and low-byte writes take their page from that register. Sequential steps and table offsets leave the page bits as they are.

Return addresses live in an eight-deep circular stack inside the block. When an interrupt is taken, the address moves to the fixed vector 0x008 in page 0, and the return address goes onto the stack. In the same cycle the block copies the accumulator value, the status byte and the page-select register into shadow storage. A return from interrupt pops the address, puts the page register back, and presents the saved accumulator and status values with a one-cycle restore pulse, so the datapath can reload them. While a handler runs, further requests are held off.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the address output and the page output are 0, the handler-active flag is 0 and the restore pulse is 0.
- R2: A step strobe alone advances the address by one, and 0x3FFF wraps to 0x0000. A cycle with no strobe leaves the address unchanged.
- R3: A jump or a call sets the address to {page register, 10-bit target}. The page value is the one held before that clock edge.
- R4: A move write sets the address to {page register, current bits 9:8, accumulator}. An add write sets it to {page register, current bits 9:8, (current bits 7:0 + accumulator) mod 256}.
- R5: A table operation adds the zero-extended accumulator to address bits 9:0 modulo 1024. Bits 13:10 stay as they were, whatever the page register holds, and the page register itself does not change.
- R6: A call pushes the current address plus one. A return pops the top entry into all 14 address bits.
- R7: The stack holds 8 entries. A ninth push without a pop overwrites the oldest entry. A pop on an empty stack returns the most recently popped entry and leaves the stack empty; straight after reset that value is 0x0000.
- R8: An interrupt request taken while no handler is active sets the address to 0x008 and sets the handler-active flag. It also pushes the current address plus one.
- R9: On interrupt entry the accumulator input, the status input and the page register are captured into shadow storage. The shadow accumulator and status values appear on their outputs from the next cycle.
- R10: A return from interrupt pops the address, reloads the page register from its shadow copy, raises the restore pulse for exactly one cycle and clears the handler-active flag.
- R11: While the handler-active flag is set, an interrupt request has no effect, and the other strobes act as they would without it.
- R12: When several strobes arrive together, the one that acts is chosen in this order: taken interrupt, return from interrupt, return, call, jump, move write, add write, table, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Sequential advance |
| jmp_en | input | 1 | Absolute jump |
| call_en | input | 1 | Subroutine call |
| ret_en | input | 1 | Subroutine return |
| reti_en | input | 1 | Return from interrupt |
| pcl_mov_en | input | 1 | Accumulator move into address low byte |
| pcl_add_en | input | 1 | Accumulator add into address low byte |
| tbl_en | input | 1 | Table-relative offset |
| jmp_tgt | input | 10 | Jump/call target within the page |
| acc_in | input | 8 | Accumulator value |
| stat_in | input | 8 | Status byte value |
| page_wr | input | 1 | Page-select register write |
| page_din | input | 4 | Page-select write data |
| irq_req | input | 1 | Interrupt request |
| pc_o | output | 14 | Current instruction address |
| page_o | output | 4 | Page-select register |
| isr_active_o | output | 1 | Handler in progress |
| ctx_restore_o | output | 1 | One-cycle pulse after return from interrupt |
| acc_shadow_o | output | 8 | Saved accumulator |
| stat_shadow_o | output | 8 | Saved status byte |

## Verification
The hardest state to reach from the ports is a stack that has wrapped and then been fully drained. Reaching it needs nine pushes with known values, eight pops that must come back newest first without the lost oldest entry, and one more pop on the empty stack. The bench first jumps to a known address and then issues a chain of calls, so every pushed value can be predicted. A chain of returns follows. For the interrupt path, the handler rewrites the page and raises a second request, and the return must undo both.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [3:0] {
    OP_HOLD,
    OP_STEP,
    OP_IRQ,
    OP_RETI,
    OP_RET,
    OP_CALL,
    OP_JMP,
    OP_MOV,
    OP_ADD,
    OP_TBL
  } pcs_op_e;
endpackage

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int W     = 14,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] sp_q, sp_d, sp_dec, sp_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty;

  assign empty  = (cnt_q == '0);
  assign sp_dec = (sp_q == '0) ? PTR_W'(DEPTH - 1) : sp_q - PTR_W'(1);
  assign sp_inc = (sp_q == PTR_W'(DEPTH - 1)) ? '0 : sp_q + PTR_W'(1);
  assign top_o  = empty ? mem_q[sp_q] : mem_q[sp_dec];

  always_comb begin
    sp_d  = sp_q;
    cnt_d = cnt_q;
    if (push) begin
      sp_d = sp_inc;
      if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      sp_d  = sp_dec;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else begin
      sp_q  <= sp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (push && (sp_q == PTR_W'(g))) begin
        mem_q[g] <= din;
      end
    end
  end
endmodule

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  parameter int VEC    = 8
) (
  input  pcs_op_e                  op,
  input  logic [PC_W-1:0]          pc_q,
  input  logic [PAGE_W-1:0]        page_q,
  input  logic [PC_W-PAGE_W-1:0]   tgt,
  input  logic [DATA_W-1:0]        acc,
  input  logic [PC_W-1:0]          pop_val,
  output logic [PC_W-1:0]          pc_d,
  output logic [PC_W-1:0]          push_val
);
  localparam int LOW_W = PC_W - PAGE_W;

  logic [PC_W-1:0]   pc_inc;
  logic [DATA_W-1:0] add_lo;
  logic [LOW_W-1:0]  tbl_lo;

  assign pc_inc   = pc_q + PC_W'(1);
  assign add_lo   = pc_q[DATA_W-1:0] + acc;
  assign tbl_lo   = pc_q[LOW_W-1:0] + LOW_W'(acc);
  assign push_val = pc_inc;

  always_comb begin
    unique case (op)
      OP_STEP:         pc_d = pc_inc;
      OP_IRQ:          pc_d = PC_W'(VEC);
      OP_RETI, OP_RET: pc_d = pop_val;
      OP_CALL, OP_JMP: pc_d = {page_q, tgt};
      OP_MOV:          pc_d = {page_q, pc_q[LOW_W-1:DATA_W], acc};
      OP_ADD:          pc_d = {page_q, pc_q[LOW_W-1:DATA_W], add_lo};
      OP_TBL:          pc_d = {pc_q[PC_W-1:LOW_W], tbl_lo};
      default:         pc_d = pc_q;
    endcase
  end
endmodule

// File: rtl/pcs_shadow.sv
module pcs_shadow #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save,
  input  logic              restore,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] stat_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic [DATA_W-1:0] acc_sv,
  output logic [DATA_W-1:0] stat_sv,
  output logic [PAGE_W-1:0] page_sv,
  output logic              restore_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sv  <= '0;
      stat_sv <= '0;
      page_sv <= '0;
    end else if (save) begin
      acc_sv  <= acc_in;
      stat_sv <= stat_in;
      page_sv <= page_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restore_pulse <= 1'b0;
    else        restore_pulse <= restore;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int VEC    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic                     jmp_en,
  input  logic                     call_en,
  input  logic                     ret_en,
  input  logic                     reti_en,
  input  logic                     pcl_mov_en,
  input  logic                     pcl_add_en,
  input  logic                     tbl_en,
  input  logic [PC_W-PAGE_W-1:0]   jmp_tgt,
  input  logic [DATA_W-1:0]        acc_in,
  input  logic [DATA_W-1:0]        stat_in,
  input  logic                     page_wr,
  input  logic [PAGE_W-1:0]        page_din,
  input  logic                     irq_req,
  output logic [PC_W-1:0]          pc_o,
  output logic [PAGE_W-1:0]        page_o,
  output logic                     isr_active_o,
  output logic                     ctx_restore_o,
  output logic [DATA_W-1:0]        acc_shadow_o,
  output logic [DATA_W-1:0]        stat_shadow_o
);
  logic            rst_meta_q, rst_sync_q;
  pcs_op_e         op;
  logic            irq_take, push, pop;
  logic [PC_W-1:0] pc_q, pc_d, push_val, pop_val;
  logic [PAGE_W-1:0] page_q, page_d, page_sv;
  logic            isr_q, isr_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign irq_take = irq_req && !isr_q;

  always_comb begin
    if      (irq_take)   op = OP_IRQ;
    else if (reti_en)    op = OP_RETI;
    else if (ret_en)     op = OP_RET;
    else if (call_en)    op = OP_CALL;
    else if (jmp_en)     op = OP_JMP;
    else if (pcl_mov_en) op = OP_MOV;
    else if (pcl_add_en) op = OP_ADD;
    else if (tbl_en)     op = OP_TBL;
    else if (step_en)    op = OP_STEP;
    else                 op = OP_HOLD;
  end

  assign push = (op == OP_IRQ) || (op == OP_CALL);
  assign pop  = (op == OP_RETI) || (op == OP_RET);

  pcs_next #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .VEC(VEC)
  ) u_next (
    .op       (op),
    .pc_q     (pc_q),
    .page_q   (page_q),
    .tgt      (jmp_tgt),
    .acc      (acc_in),
    .pop_val  (pop_val),
    .pc_d     (pc_d),
    .push_val (push_val)
  );

  pcs_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .push  (push),
    .pop   (pop),
    .din   (push_val),
    .top_o (pop_val)
  );

  pcs_shadow #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_shadow (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .save          (op == OP_IRQ),
    .restore       (op == OP_RETI),
    .acc_in        (acc_in),
    .stat_in       (stat_in),
    .page_in       (page_q),
    .acc_sv        (acc_shadow_o),
    .stat_sv       (stat_shadow_o),
    .page_sv       (page_sv),
    .restore_pulse (ctx_restore_o)
  );

  always_comb begin
    page_d = page_q;
    if (op == OP_RETI)  page_d = page_sv;
    else if (page_wr)   page_d = page_din;
  end

  always_comb begin
    isr_d = isr_q;
    if (op == OP_IRQ)       isr_d = 1'b1;
    else if (op == OP_RETI) isr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      pc_q   <= '0;
      page_q <= '0;
      isr_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      page_q <= page_d;
      isr_q  <= isr_d;
    end
  end

  assign pc_o         = pc_q;
  assign page_o       = page_q;
  assign isr_active_o = isr_q;
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int PC_W   = 14,
  parameter int PAGE_W = 4,
  parameter int VEC    = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   step_en,
  input logic                   jmp_en,
  input logic                   call_en,
  input logic                   ret_en,
  input logic                   reti_en,
  input logic                   pcl_mov_en,
  input logic                   pcl_add_en,
  input logic                   tbl_en,
  input logic                   irq_req,
  input logic [PC_W-PAGE_W-1:0] jmp_tgt,
  input logic [PC_W-1:0]        pc_o,
  input logic [PAGE_W-1:0]      page_o,
  input logic                   isr_active_o,
  input logic                   ctx_restore_o
);
  localparam int LOW_W = PC_W - PAGE_W;

  logic taken, above_jmp, any_other;
  assign taken     = irq_req && !isr_active_o;
  assign above_jmp = taken || reti_en || ret_en || call_en;
  assign any_other = irq_req || reti_en || ret_en || call_en || jmp_en ||
                     pcl_mov_en || pcl_add_en;

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !any_other && !tbl_en) |=> (pc_o == $past(pc_o) + PC_W'(1)));

  // R3
  jump_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_en && !above_jmp) |=>
      (pc_o[PC_W-1:LOW_W] == $past(page_o) && pc_o[LOW_W-1:0] == $past(jmp_tgt)));

  // R5
  tbl_page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_en && !any_other) |=> (pc_o[PC_W-1:LOW_W] == $past(pc_o[PC_W-1:LOW_W])));

  // R8
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (pc_o == PC_W'(VEC) && isr_active_o));

  // R11
  isr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_active_o && !reti_en) |=> isr_active_o);

  // R10
  reti_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_en && !taken) |=> (!isr_active_o && ctx_restore_o));

  // R10
  restore_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restore_o |-> $past(reti_en));
endmodule

bind pc_sequencer pcs_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .VEC(VEC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_q),
  .step_en       (step_en),
  .jmp_en        (jmp_en),
  .call_en       (call_en),
  .ret_en        (ret_en),
  .reti_en       (reti_en),
  .pcl_mov_en    (pcl_mov_en),
  .pcl_add_en    (pcl_add_en),
  .tbl_en        (tbl_en),
  .irq_req       (irq_req),
  .jmp_tgt       (jmp_tgt),
  .pc_o          (pc_o),
  .page_o        (page_o),
  .isr_active_o  (isr_active_o),
  .ctx_restore_o (ctx_restore_o)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  logic       clk, rst_n;
  logic       step_en, jmp_en, call_en, ret_en, reti_en;
  logic       pcl_mov_en, pcl_add_en, tbl_en, page_wr, irq_req;
  logic [9:0] jmp_tgt;
  logic [7:0] acc_in, stat_in;
  logic [3:0] page_din;
  logic [13:0] pc_o;
  logic [3:0]  page_o;
  logic        isr_active_o, ctx_restore_o;
  logic [7:0]  acc_shadow_o, stat_shadow_o;

  int n_chk = 0;
  int n_bad = 0;

  pc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .jmp_en(jmp_en),
    .call_en(call_en), .ret_en(ret_en), .reti_en(reti_en),
    .pcl_mov_en(pcl_mov_en), .pcl_add_en(pcl_add_en), .tbl_en(tbl_en),
    .jmp_tgt(jmp_tgt), .acc_in(acc_in), .stat_in(stat_in),
    .page_wr(page_wr), .page_din(page_din), .irq_req(irq_req),
    .pc_o(pc_o), .page_o(page_o), .isr_active_o(isr_active_o),
    .ctx_restore_o(ctx_restore_o), .acc_shadow_o(acc_shadow_o),
    .stat_shadow_o(stat_shadow_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    step_en = 0; jmp_en = 0; call_en = 0; ret_en = 0; reti_en = 0;
    pcl_mov_en = 0; pcl_add_en = 0; tbl_en = 0; page_wr = 0; irq_req = 0;
  endtask

  // inputs set after a falling edge are applied for one rising edge,
  // results are read at the next falling edge
  task automatic finish_cycle();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_page(input logic [3:0] p);
    page_wr = 1; page_din = p; finish_cycle();
  endtask

  task automatic do_jump(input logic [9:0] t);
    jmp_en = 1; jmp_tgt = t; finish_cycle();
  endtask

  task automatic do_call(input logic [9:0] t);
    call_en = 1; jmp_tgt = t; finish_cycle();
  endtask

  task automatic do_ret();
    ret_en = 1; finish_cycle();
  endtask

  task automatic t_reset();
    check("R1 pc", pc_o, 0);
    check("R1 page", page_o, 0);
    check("R1 active", isr_active_o, 0);
    check("R1 restore", ctx_restore_o, 0);
  endtask

  task automatic t_step();
    step_en = 1; finish_cycle();
    step_en = 1; finish_cycle();
    check("R2 step", pc_o, 14'h0002);
    finish_cycle();
    check("R2 hold", pc_o, 14'h0002);
    set_page(4'hF);
    do_jump(10'h3FF);
    check("R3 jump page15", pc_o, 14'h3FFF);
    step_en = 1; finish_cycle();
    check("R2 wrap", pc_o, 14'h0000);
  endtask

  task automatic t_jump_pcl();
    set_page(4'h5);
    do_jump(10'h2F0);
    check("R3 jump", pc_o, 14'h16F0);
    set_page(4'h6);
    pcl_mov_en = 1; acc_in = 8'hAB; finish_cycle();
    check("R4 mov", pc_o, 14'h1AAB);
    pcl_add_en = 1; acc_in = 8'h60; finish_cycle();
    check("R4 add", pc_o, 14'h1A0B);
  endtask

  task automatic t_table();
    set_page(4'h3);
    do_jump(10'h3F0);
    check("R3 jump", pc_o, 14'h0FF0);
    set_page(4'h7);
    tbl_en = 1; acc_in = 8'h20; finish_cycle();
    check("R5 tbl", pc_o, 14'h0C10);
    check("R5 page reg", page_o, 4'h7);
  endtask

  task automatic t_call_ret();
    do_jump(10'h040);
    check("R3 jump", pc_o, 14'h1C40);
    do_call(10'h100);
    check("R3 call", pc_o, 14'h1D00);
    step_en = 1; finish_cycle();
    do_ret();
    check("R6 ret", pc_o, 14'h1C41);
  endtask

  task automatic t_stack();
    set_page(4'h0);
    do_jump(10'h100);
    for (int i = 0; i < 9; i++) do_call(10'h200 + 10'(i));
    check("R6 call chain", pc_o, 14'h0208);
    for (int i = 8; i >= 1; i--) begin
      do_ret();
      check("R7 pop order", pc_o, 14'h0200 + 14'(i));
    end
    do_ret();
    check("R7 empty pop", pc_o, 14'h0201);
  endtask

  task automatic t_irq();
    set_page(4'h2);
    do_jump(10'h050);
    check("R3 jump", pc_o, 14'h0850);
    irq_req = 1; jmp_en = 1; jmp_tgt = 10'h3FF;
    acc_in = 8'h5A; stat_in = 8'h3C; finish_cycle();
    check("R12 irq wins", pc_o, 14'h0008);
    check("R8 active", isr_active_o, 1);
    check("R9 acc", acc_shadow_o, 8'h5A);
    check("R9 stat", stat_shadow_o, 8'h3C);
    set_page(4'h9);
    irq_req = 1; step_en = 1; acc_in = 8'h11; stat_in = 8'h22; finish_cycle();
    check("R11 no nest pc", pc_o, 14'h0009);
    check("R11 shadow kept", acc_shadow_o, 8'h5A);
    reti_en = 1; ret_en = 1; finish_cycle();
    check("R10 pc", pc_o, 14'h0851);
    check("R10 page", page_o, 4'h2);
    check("R10 pulse", ctx_restore_o, 1);
    check("R10 active", isr_active_o, 0);
    check("R10 stat", stat_shadow_o, 8'h3C);
    finish_cycle();
    check("R10 pulse one", ctx_restore_o, 0);
    irq_req = 1; finish_cycle();
    check("R8 again", pc_o, 14'h0008);
  endtask

  task automatic t_empty_after_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    step_en = 1; finish_cycle();
    do_ret();
    check("R7 empty after reset", pc_o, 14'h0000);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    jmp_tgt = '0; acc_in = '0; stat_in = '0; page_din = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_step();
    t_jump_pcl();
    t_table();
    t_call_ret();
    t_stack();
    t_irq();
    t_empty_after_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule